// File: doc/BRIEF.md
# Two-Address Host Port with Packet Buffer Access

This block is the host-facing slave of a network controller. A processor reaches it through just two bus addresses. A write to the command address stores an 8-bit register selector. Later reads and writes of the data address act on whichever register that selector names. The bus strobes are active low and are sampled on the block clock. Writes act when the write strobe falls. Read side effects take place when the read strobe rises again, so the data on the bus stays steady while the strobe is held.

A few selector values do not name a plain register. Instead they stream bytes to and from an internal packet memory. The memory is split into a transmit region at the bottom and a receive region above it. The host writes transmit bytes through an auto-advancing write pointer. It drains receive bytes either through an advancing read pointer or through a peek that leaves the pointer alone but refreshes the read buffer. In 16-bit bus mode, every memory transfer is a little-endian halfword and each pointer moves by two.

The receive side of the network logic deposits bytes through a separate memory write port. It reports finished frames as single-cycle event pulses. Those events set interrupt status bits, and a maskable interrupt pin summarises them.

Top module: `idxHostPort`

## Requirements
- R1: A write with `csN` low and `cmdSel`=0 loads the selector from `busDin[7:0]`. A read with `cmdSel`=0 returns the selector on `busDout[7:0]`, which is 00h after reset.
- R2: Selectors FAh/FBh read and write the low/high byte of the write pointer, F4h/F5h the low/high byte of the read pointer, and FCh/FDh the low/high byte of a 16-bit length register. Pointer bits above the address width read 0. Register reads drive `busDout[15:8]`=0. After reset the write pointer is 0, the read pointer equals TX_BYTES, and the length is 0.
- R3: A data write with selector F8h stores `busDin[7:0]` at the write pointer and advances it by 1 when `busWide`=0. When `busWide`=1 it stores `busDin[7:0]` at the pointer and `busDin[15:8]` at the next address, and advances by 2.
- R4: The write pointer stays inside the transmit region 0..TX_BYTES-1. Stepping past TX_BYTES-1 continues from 0, and this applies to the second byte of a halfword as well.
- R5: A data read with selector F2h returns the byte at the read pointer when `busWide`=0. When `busWide`=1 it returns {byte at pointer+1, byte at pointer}. When the read strobe ends, the pointer advances by 1 or 2 respectively.
- R6: The read pointer stays inside the receive region TX_BYTES..MEM_BYTES-1. Stepping past MEM_BYTES-1 continues from TX_BYTES, and this applies to the upper byte of a halfword as well.
- R7: A data read with selector F0h returns the buffered data in the same format as F2h and leaves the read pointer unchanged. It then reloads the buffer from memory, so a later read shows bytes written after the previous load.
- R8: After a read strobe on F0h/F2h ends, or after a write to F4h/F5h, the new buffered data is on `busDout` two clock cycles later.
- R9: Selector FEh holds status bit 0 (frame received, set by `rxDoneEv`) and bit 1 (frame sent, set by `txDoneEv`). Writing 1 to a bit clears it and writing 0 leaves it. The other bits read 0.
- R10: Selector FFh holds a 2-bit mask in bits 1:0, and its other bits read 0. `intOut` is active when any status bit is set together with its mask bit. It is active high when INT_ACT_LOW=0 and active low when INT_ACT_LOW=1.
- R11: Write strobes given while `csN` is high change neither the selector nor any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWide | input | 1 | 1 selects 16-bit bus mode, 0 selects 8-bit |
| csN | input | 1 | Active-low chip select |
| cmdSel | input | 1 | 0 addresses the selector port, 1 the data port |
| rdN | input | 1 | Active-low read strobe |
| wrN | input | 1 | Active-low write strobe |
| busDin | input | 16 | Host write data |
| busDout | output | 16 | Host read data |
| macWrEn | input | 1 | Network-side memory write enable |
| macWrAddr | input | AW | Network-side memory byte address |
| macWrData | input | 8 | Network-side memory write byte |
| txDoneEv | input | 1 | One-cycle pulse: a frame has been sent |
| rxDoneEv | input | 1 | One-cycle pulse: a frame has been received |
| intOut | output | 1 | Interrupt pin, polarity set by INT_ACT_LOW |

## Verification
A pointer that steps by the wrong amount or wraps at the wrong bound does not stay hidden. It shows on the very next F2h read as a byte from the wrong address, and on the FAh/F4h read-back as a wrong pointer value. A buffer that is not reloaded after a peek or a pointer load gives stale bytes on the first memory read that follows. Status or mask state that is wrong shows on `intOut` within one clock of the event or register write, and on the FEh/FFh read-back.

// File: rtl/hpPkg.sv
package hpPkg;

  // single-cycle strobes from the bus control to the datapath
  typedef struct packed {
    logic idxWr;   // selector write
    logic dataWr;  // data port write
    logic rdDone;  // end of a data port read
  } hostStrobe_t;

  localparam logic [7:0] IDX_PEEK   = 8'hF0;
  localparam logic [7:0] IDX_POP    = 8'hF2;
  localparam logic [7:0] IDX_RDA_LO = 8'hF4;
  localparam logic [7:0] IDX_RDA_HI = 8'hF5;
  localparam logic [7:0] IDX_PUSH   = 8'hF8;
  localparam logic [7:0] IDX_WRA_LO = 8'hFA;
  localparam logic [7:0] IDX_WRA_HI = 8'hFB;
  localparam logic [7:0] IDX_LEN_LO = 8'hFC;
  localparam logic [7:0] IDX_LEN_HI = 8'hFD;
  localparam logic [7:0] IDX_STAT   = 8'hFE;
  localparam logic [7:0] IDX_MASK   = 8'hFF;

endpackage

// File: rtl/hpSram.sv
module hpSram #(
  parameter int MEM_BYTES = 512,
  parameter int AW        = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          wrEnLo,
  input  logic [AW-1:0] wrAddrLo,
  input  logic [7:0]    wrDataLo,
  input  logic          wrEnHi,
  input  logic [AW-1:0] wrAddrHi,
  input  logic [7:0]    wrDataHi,
  input  logic          macWrEn,
  input  logic [AW-1:0] macWrAddr,
  input  logic [7:0]    macWrData,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddrLo,
  input  logic [AW-1:0] rdAddrHi,
  output logic [7:0]    rdLo,
  output logic [7:0]    rdHi
);

  logic [7:0] mem [MEM_BYTES];

  // the output registers double as the prefetch buffer
  always_ff @(posedge clk) begin
    if (wrEnLo)  mem[wrAddrLo]  <= wrDataLo;
    if (wrEnHi)  mem[wrAddrHi]  <= wrDataHi;
    if (macWrEn) mem[macWrAddr] <= macWrData;
    if (rdEn) begin
      rdLo <= mem[rdAddrLo];
      rdHi <= mem[rdAddrHi];
    end
  end

endmodule

// File: rtl/hpCtrl.sv
module hpCtrl
  import hpPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        csN,
  input  logic        cmdSel,
  input  logic        rdN,
  input  logic        wrN,
  input  logic [7:0]  idxIn,
  output hostStrobe_t st,
  output logic [7:0]  curIdx
);

  logic rdPrev, wrPrev, rdOpen;
  logic wrFall, rdFall, rdRise;

  assign wrFall = wrPrev & ~wrN & ~csN;
  assign rdFall = rdPrev & ~rdN & ~csN;
  assign rdRise = ~rdPrev & rdN;

  always_comb begin
    st.idxWr  = wrFall & ~cmdSel;
    st.dataWr = wrFall & cmdSel;
    st.rdDone = rdRise & rdOpen;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPrev <= 1'b1;
      wrPrev <= 1'b1;
      rdOpen <= 1'b0;
      curIdx <= 8'h00;
    end else begin
      rdPrev <= rdN;
      wrPrev <= wrN;
      if (rdFall)      rdOpen <= cmdSel;
      else if (rdRise) rdOpen <= 1'b0;
      if (st.idxWr)    curIdx <= idxIn;
    end
  end

endmodule

// File: rtl/hpDatapath.sv
module hpDatapath
  import hpPkg::*;
#(
  parameter int MEM_BYTES   = 512,
  parameter int TX_BYTES    = 192,
  parameter bit INT_ACT_LOW = 1'b0,
  parameter int AW          = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWide,
  input  logic          csN,
  input  logic          cmdSel,
  input  logic [7:0]    curIdx,
  input  hostStrobe_t   st,
  input  logic [15:0]   busDin,
  input  logic          macWrEn,
  input  logic [AW-1:0] macWrAddr,
  input  logic [7:0]    macWrData,
  input  logic          txDoneEv,
  input  logic          rxDoneEv,
  output logic [15:0]   busDout,
  output logic          intOut
);

  localparam int            RX_SIZE = MEM_BYTES - TX_BYTES;
  localparam logic [AW:0]   TX_LIM  = (AW+1)'(TX_BYTES);
  localparam logic [AW:0]   MEM_LIM = (AW+1)'(MEM_BYTES);
  localparam logic [AW:0]   RX_SPAN = (AW+1)'(RX_SIZE);
  localparam logic [AW-1:0] RX_BASE = AW'(TX_BYTES);

  logic [AW-1:0] wrPtr, rdPtr, wrHiAddr, rdHiAddr;
  logic [15:0]   txLen;
  logic [1:0]    isr, imr, isrClr;
  logic          fetchPend, fetchReq;
  logic [1:0]    stepSz;
  logic [7:0]    pfLo, pfHi;
  logic          wantPush, wantPop, wantPeek;
  logic [15:0]   wr16, rd16;

  function automatic logic [AW-1:0] stepTx(input logic [AW-1:0] p, input logic [1:0] s);
    logic [AW:0] n;
    n = {1'b0, p} + (AW+1)'(s);
    if (n >= TX_LIM) n = n - TX_LIM;
    return n[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] stepRx(input logic [AW-1:0] p, input logic [1:0] s);
    logic [AW:0] n;
    n = {1'b0, p} + (AW+1)'(s);
    if (n >= MEM_LIM) n = n - RX_SPAN;
    return n[AW-1:0];
  endfunction

  function automatic logic [AW-1:0] putByte(input logic [AW-1:0] p, input logic hi,
                                            input logic [7:0] b);
    logic [15:0] t;
    t = 16'(p);
    if (hi) t[15:8] = b;
    else    t[7:0]  = b;
    return t[AW-1:0];
  endfunction

  assign stepSz   = busWide ? 2'd2 : 2'd1;
  assign wantPush = st.dataWr && (curIdx == IDX_PUSH);
  assign wantPop  = st.rdDone && (curIdx == IDX_POP);
  assign wantPeek = st.rdDone && (curIdx == IDX_PEEK);
  assign wrHiAddr = stepTx(wrPtr, 2'd1);
  assign rdHiAddr = stepRx(rdPtr, 2'd1);
  assign fetchReq = wantPop | wantPeek |
                    (st.dataWr && (curIdx == IDX_RDA_LO || curIdx == IDX_RDA_HI));
  assign isrClr   = (st.dataWr && curIdx == IDX_STAT) ? busDin[1:0] : 2'b00;
  assign wr16     = 16'(wrPtr);
  assign rd16     = 16'(rdPtr);

  hpSram #(.MEM_BYTES(MEM_BYTES), .AW(AW)) uMem (
    .clk      (clk),
    .wrEnLo   (wantPush),
    .wrAddrLo (wrPtr),
    .wrDataLo (busDin[7:0]),
    .wrEnHi   (wantPush & busWide),
    .wrAddrHi (wrHiAddr),
    .wrDataHi (busDin[15:8]),
    .macWrEn  (macWrEn),
    .macWrAddr(macWrAddr),
    .macWrData(macWrData),
    .rdEn     (fetchPend),
    .rdAddrLo (rdPtr),
    .rdAddrHi (rdHiAddr),
    .rdLo     (pfLo),
    .rdHi     (pfHi)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= RX_BASE;
      txLen     <= '0;
      isr       <= '0;
      imr       <= '0;
      fetchPend <= 1'b1;
    end else begin
      if (wantPush)                                   wrPtr <= stepTx(wrPtr, stepSz);
      else if (st.dataWr && curIdx == IDX_WRA_LO)     wrPtr <= putByte(wrPtr, 1'b0, busDin[7:0]);
      else if (st.dataWr && curIdx == IDX_WRA_HI)     wrPtr <= putByte(wrPtr, 1'b1, busDin[7:0]);

      if (wantPop)                                    rdPtr <= stepRx(rdPtr, stepSz);
      else if (st.dataWr && curIdx == IDX_RDA_LO)     rdPtr <= putByte(rdPtr, 1'b0, busDin[7:0]);
      else if (st.dataWr && curIdx == IDX_RDA_HI)     rdPtr <= putByte(rdPtr, 1'b1, busDin[7:0]);

      if (st.dataWr && curIdx == IDX_LEN_LO)          txLen[7:0]  <= busDin[7:0];
      if (st.dataWr && curIdx == IDX_LEN_HI)          txLen[15:8] <= busDin[7:0];
      if (st.dataWr && curIdx == IDX_MASK)            imr <= busDin[1:0];

      isr       <= (isr & ~isrClr) | {txDoneEv, rxDoneEv};
      fetchPend <= fetchReq;
    end
  end

  always_comb begin
    busDout = '0;
    if (!cmdSel) begin
      busDout[7:0] = curIdx;
    end else begin
      case (curIdx)
        IDX_PEEK, IDX_POP: busDout = busWide ? {pfHi, pfLo} : {8'h00, pfLo};
        IDX_RDA_LO:        busDout[7:0] = rd16[7:0];
        IDX_RDA_HI:        busDout[7:0] = rd16[15:8];
        IDX_WRA_LO:        busDout[7:0] = wr16[7:0];
        IDX_WRA_HI:        busDout[7:0] = wr16[15:8];
        IDX_LEN_LO:        busDout[7:0] = txLen[7:0];
        IDX_LEN_HI:        busDout[7:0] = txLen[15:8];
        IDX_STAT:          busDout[1:0] = isr;
        IDX_MASK:          busDout[1:0] = imr;
        default:           busDout = '0;
      endcase
    end
  end

  assign intOut = (|(isr & imr)) ^ INT_ACT_LOW;

  // R4
  wrptr_tx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wantPush && ({1'b0, wrPtr} < TX_LIM)) |=> ({1'b0, wrPtr} < TX_LIM));

  // R6
  rdptr_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wantPop && (rdPtr >= RX_BASE)) |=> (rdPtr >= RX_BASE));

  // R7
  peek_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wantPeek |=> (rdPtr == $past(rdPtr)));

  // R9
  isr_w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.dataWr && curIdx == IDX_STAT && !txDoneEv && !rxDoneEv)
      |=> ((isr & $past(busDin[1:0])) == 2'b00));

  // R11
  cs_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !(st.idxWr || st.dataWr));

endmodule

// File: rtl/idxHostPort.sv
module idxHostPort
  import hpPkg::*;
#(
  parameter int MEM_BYTES   = 512,
  parameter int TX_BYTES    = 192,
  parameter bit INT_ACT_LOW = 1'b0,
  localparam int AW         = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busWide,
  input  logic          csN,
  input  logic          cmdSel,
  input  logic          rdN,
  input  logic          wrN,
  input  logic [15:0]   busDin,
  output logic [15:0]   busDout,
  input  logic          macWrEn,
  input  logic [AW-1:0] macWrAddr,
  input  logic [7:0]    macWrData,
  input  logic          txDoneEv,
  input  logic          rxDoneEv,
  output logic          intOut
);

  hostStrobe_t st;
  logic [7:0]  curIdx;

  hpCtrl uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .csN   (csN),
    .cmdSel(cmdSel),
    .rdN   (rdN),
    .wrN   (wrN),
    .idxIn (busDin[7:0]),
    .st    (st),
    .curIdx(curIdx)
  );

  hpDatapath #(
    .MEM_BYTES  (MEM_BYTES),
    .TX_BYTES   (TX_BYTES),
    .INT_ACT_LOW(INT_ACT_LOW),
    .AW         (AW)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .busWide  (busWide),
    .csN      (csN),
    .cmdSel   (cmdSel),
    .curIdx   (curIdx),
    .st       (st),
    .busDin   (busDin),
    .macWrEn  (macWrEn),
    .macWrAddr(macWrAddr),
    .macWrData(macWrData),
    .txDoneEv (txDoneEv),
    .rxDoneEv (rxDoneEv),
    .busDout  (busDout),
    .intOut   (intOut)
  );

endmodule

// File: tb/sim_idxHostPort.sv
module sim_idxHostPort;

  localparam int MB = 512;
  localparam int TB = 200;
  localparam int AW = 9;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, busWide, csN, cmdSel, rdN, wrN;
  logic [15:0] busDin, busDout;
  logic macWrEn;
  logic [AW-1:0] macWrAddr;
  logic [7:0] macWrData;
  logic txDoneEv, rxDoneEv, intOut;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;
  logic [7:0] model [MB];

  idxHostPort #(.MEM_BYTES(MB), .TX_BYTES(TB), .INT_ACT_LOW(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .busWide(busWide), .csN(csN), .cmdSel(cmdSel),
    .rdN(rdN), .wrN(wrN), .busDin(busDin), .busDout(busDout),
    .macWrEn(macWrEn), .macWrAddr(macWrAddr), .macWrData(macWrData),
    .txDoneEv(txDoneEv), .rxDoneEv(rxDoneEv), .intOut(intOut)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hostWr(input logic c, input logic [15:0] d);
    @(negedge clk); csN = 1'b0; cmdSel = c; busDin = d;
    @(negedge clk); wrN = 1'b0;
    @(negedge clk); wrN = 1'b1; csN = 1'b1;
  endtask

  task automatic hostRd(input logic c, output logic [15:0] d);
    @(negedge clk); csN = 1'b0; cmdSel = c;
    @(negedge clk); rdN = 1'b0;
    @(negedge clk);
    @(negedge clk); d = busDout; rdN = 1'b1; csN = 1'b1;
  endtask

  task automatic setReg(input logic [7:0] idx, input logic [15:0] v);
    hostWr(1'b0, {8'h00, idx});
    hostWr(1'b1, v);
  endtask

  task automatic getReg(input logic [7:0] idx, output logic [15:0] v);
    hostWr(1'b0, {8'h00, idx});
    hostRd(1'b1, v);
  endtask

  task automatic macPut(input int a, input logic [7:0] d);
    @(negedge clk); macWrEn = 1'b1; macWrAddr = AW'(a); macWrData = d;
    @(negedge clk); macWrEn = 1'b0;
    model[a] = d;
  endtask

  task automatic setRdPtr(input int a);
    setReg(8'hF4, 16'(a & 255));
    setReg(8'hF5, 16'(a >> 8));
  endtask

  task automatic setWrPtr(input int a);
    setReg(8'hFA, 16'(a & 255));
    setReg(8'hFB, 16'(a >> 8));
  endtask

  task automatic pulse(input bit tx);
    @(negedge clk); if (tx) txDoneEv = 1'b1; else rxDoneEv = 1'b1;
    @(negedge clk); txDoneEv = 1'b0; rxDoneEv = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired (all requirements): actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    rstN = 1'b0; busWide = 1'b0; csN = 1'b1; cmdSel = 1'b0; rdN = 1'b1; wrN = 1'b1;
    busDin = '0; macWrEn = 1'b0; macWrAddr = '0; macWrData = '0;
    txDoneEv = 1'b0; rxDoneEv = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // reset state
    hostRd(1'b0, v);   check("R1 reset selector", v, 16'h0000);
    check("R10 reset intOut inactive", {15'h0, intOut}, 16'h0001);
    getReg(8'hF4, v);  check("R2 reset read ptr low", v, 16'(TB & 255));
    getReg(8'hFA, v);  check("R2 reset write ptr low", v, 16'h0000);
    getReg(8'hFC, v);  check("R2 reset length low", v, 16'h0000);
    getReg(8'hFE, v);  check("R9 reset status", v, 16'h0000);

    // R1 selector write and read-back
    hostWr(1'b0, 16'h00FC);
    hostRd(1'b0, v);   check("R1 selector read-back", v, 16'h00FC);

    // R11 strobes with chip select high
    @(negedge clk); csN = 1'b1; cmdSel = 1'b1; busDin = 16'h0077;
    @(negedge clk); wrN = 1'b0;
    @(negedge clk); wrN = 1'b1;
    @(negedge clk); cmdSel = 1'b0; busDin = 16'h0033;
    @(negedge clk); wrN = 1'b0;
    @(negedge clk); wrN = 1'b1;
    hostRd(1'b0, v);   check("R11 selector kept", v, 16'h00FC);
    hostRd(1'b1, v);   check("R11 length kept", v, 16'h0000);

    // R2 register access
    setReg(8'hFC, 16'h0034); setReg(8'hFD, 16'h0012);
    getReg(8'hFC, v);  check("R2 length low", v, 16'h0034);
    getReg(8'hFD, v);  check("R2 length high", v, 16'h0012);
    setReg(8'hFB, 16'h00FF);
    getReg(8'hFB, v);  check("R2 write ptr high masked", v, 16'h0001);
    setReg(8'hFA, 16'h005C);
    getReg(8'hFA, v);  check("R2 write ptr low", v, 16'h005C);

    // R3/R4 8-bit push sweep across the transmit wrap
    setWrPtr(0);
    hostWr(1'b0, 16'h00F8);
    for (int i = 0; i < TB + 10; i++) begin
      logic [7:0] d;
      d = 8'((i * 7 + 3) & 255);
      hostWr(1'b1, {8'hEE, d});
      model[i % TB] = d;
    end
    getReg(8'hFA, v);  check("R4 write ptr after wrap", v, 16'd10);
    getReg(8'hFB, v);  check("R4 write ptr high after wrap", v, 16'h0000);

    // R5/R8 8-bit pop sweep, back-to-back reads
    setRdPtr(0);
    hostWr(1'b0, 16'h00F2);
    for (int a = 0; a < TB; a++) begin
      hostRd(1'b1, v);
      check("R3 R5 R8 pop byte", v, {8'h00, model[a]});
    end
    getReg(8'hF4, v);  check("R5 read ptr advanced", v, 16'(TB & 255));

    // fill receive region from the network side
    for (int a = TB; a < MB; a++) macPut(a, 8'((a * 5 + 1) & 255));

    // R6 8-bit receive wrap
    setRdPtr(MB - 4);
    hostWr(1'b0, 16'h00F2);
    for (int k = 0; k < 6; k++) begin
      int a;
      a = (k < 4) ? (MB - 4 + k) : (TB + k - 4);
      hostRd(1'b1, v);
      check("R6 wrapped pop byte", v, {8'h00, model[a]});
    end
    getReg(8'hF4, v);  check("R6 read ptr low after wrap", v, 16'((TB + 2) & 255));
    getReg(8'hF5, v);  check("R6 read ptr high after wrap", v, 16'((TB + 2) >> 8));

    // R7 peek returns buffer, keeps pointer, refreshes buffer
    macPut(300, 8'h11);
    setRdPtr(300);
    repeat (3) @(negedge clk);
    macPut(300, 8'h5A);
    hostWr(1'b0, 16'h00F0);
    hostRd(1'b1, v);   check("R7 peek returns stale buffer", v, 16'h0011);
    hostRd(1'b1, v);   check("R7 R8 peek after refresh", v, 16'h005A);
    getReg(8'hF4, v);  check("R7 pointer unchanged low", v, 16'(300 & 255));
    getReg(8'hF5, v);  check("R7 pointer unchanged high", v, 16'(300 >> 8));

    // 16-bit mode
    @(negedge clk); busWide = 1'b1;
    setWrPtr(TB - 4);
    hostWr(1'b0, 16'h00F8);
    hostWr(1'b1, 16'hA1B2); model[TB-4] = 8'hB2; model[TB-3] = 8'hA1;
    hostWr(1'b1, 16'hC3D4); model[TB-2] = 8'hD4; model[TB-1] = 8'hC3;
    hostWr(1'b1, 16'hE5F6); model[0]    = 8'hF6; model[1]    = 8'hE5;
    getReg(8'hFA, v);  check("R3 R4 wide push ptr", v, 16'd2);
    setWrPtr(TB - 1);
    hostWr(1'b0, 16'h00F8);
    hostWr(1'b1, 16'h7788); model[TB-1] = 8'h88; model[0] = 8'h77;
    getReg(8'hFA, v);  check("R4 odd wide push ptr", v, 16'd1);

    setRdPtr(TB - 4);
    hostWr(1'b0, 16'h00F2);
    for (int k = 0; k < 3; k++) begin
      int a;
      a = TB - 4 + 2 * k;
      hostRd(1'b1, v);
      check("R3 R5 wide pop", v, {model[a+1], model[a]});
    end
    setRdPtr(0);
    hostWr(1'b0, 16'h00F2);
    hostRd(1'b1, v);   check("R4 R5 wide pop wrapped bytes", v, {model[1], model[0]});

    // R6 16-bit receive wrap, odd start
    setRdPtr(MB - 3);
    hostWr(1'b0, 16'h00F2);
    hostRd(1'b1, v);   check("R6 wide pop before end", v, {model[MB-2], model[MB-3]});
    hostRd(1'b1, v);   check("R6 wide pop straddling end", v, {model[TB], model[MB-1]});
    hostRd(1'b1, v);   check("R6 wide pop after wrap", v, {model[TB+2], model[TB+1]});
    getReg(8'hF4, v);  check("R6 wide read ptr", v, 16'((TB + 3) & 255));
    getReg(8'hFD, v);  check("R2 wide register read upper zero", v, 16'h0012);

    // R9/R10 status, mask and interrupt pin (active low instance)
    @(negedge clk); busWide = 1'b0;
    pulse(1'b0);
    check("R10 masked status keeps pin idle", {15'h0, intOut}, 16'h0001);
    getReg(8'hFE, v);  check("R9 rx status set", v, 16'h0001);
    setReg(8'hFF, 16'h0001);
    @(negedge clk);
    check("R10 unmasked rx drives pin", {15'h0, intOut}, 16'h0000);
    setReg(8'hFE, 16'h0002);
    getReg(8'hFE, v);  check("R9 writing 0 keeps bit", v, 16'h0001);
    check("R10 pin still active", {15'h0, intOut}, 16'h0000);
    setReg(8'hFE, 16'h0001);
    getReg(8'hFE, v);  check("R9 write 1 clears", v, 16'h0000);
    check("R10 pin released", {15'h0, intOut}, 16'h0001);
    setReg(8'hFF, 16'h00FF);
    getReg(8'hFF, v);  check("R10 mask reserved bits", v, 16'h0003);
    pulse(1'b1);
    check("R10 tx event drives pin", {15'h0, intOut}, 16'h0000);
    getReg(8'hFE, v);  check("R9 tx status set", v, 16'h0002);
    setReg(8'hFE, 16'h00FF);
    getReg(8'hFE, v);  check("R9 clear all", v, 16'h0000);
    check("R10 pin idle after clear", {15'h0, intOut}, 16'h0001);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule